// File: doc/BRIEF.md
# Two-Layer Tile Alpha Blender

This block performs one composition pass over a tile. It takes two pixel streams, a foreground layer and the background composite built so far, and merges them pixel by pixel into one output stream that is written back to a tile buffer. A full picture is built in three passes. The first pass puts the still picture over the background colour. The second pass lays video over that result. The third pass lays the on-screen graphics over everything. Each pass runs through this block with different settings.

Each foreground pixel carries a 6-bit alpha, which can be a region constant or a per-pixel value. There are three pass types. Blend mixes the two layers using the supplied alpha. Fade replaces the foreground with a programmable constant colour and uses a programmable fade level as the alpha, so the layer underneath fades toward that colour. Copy passes the foreground through and ignores the background. The pass type, fade colour and fade level are captured once per tile, on its first pixel. Format conversion, resizing and memory access are handled elsewhere.

Top module: `tile_alpha_mixer`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0 until the first pair of pixels has been accepted.
- R2: A foreground pixel is accepted exactly when a background pixel is accepted. A pair is taken only when both inputs are valid and the output register is empty or being drained. Every accepted pair produces exactly one output pixel, in order.
- R3: In blend mode (`mode_cfg` = 0), each 8-bit component of the output is (a*fg + (63-a)*bg + 31)/63, using integer division, where a is `fg_alpha`. Component 0 is bits 7:0, component 1 is bits 15:8 and component 2 is bits 23:16.
- R4: In blend mode, alpha 63 outputs the foreground pixel exactly and alpha 0 outputs the background pixel exactly.
- R5: In fade mode (`mode_cfg` = 1), the formula of R3 is applied with `fade_color` in place of the foreground and `fade_level` in place of the alpha. `fg_pix` and `fg_alpha` have no effect on the output.
- R6: In copy mode (`mode_cfg` = 2), the output equals `fg_pix`. `bg_pix` and `fg_alpha` have no effect.
- R7: Mode code 3 behaves exactly as blend mode.
- R8: `mode_cfg`, `fade_color` and `fade_level` are captured with the first pixel pair of each tile and apply to the whole tile. Changes to them during the rest of the tile have no effect on that tile.
- R9: `out_last` is 1 on every TILE_PIX-th output pixel (16 by default) counted from reset, and 0 on all others.
- R10: The output has one cycle of latency. While `out_valid` is 1 and `out_ready` is 0, `out_pix` and `out_last` hold their values and no new pair is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_cfg | input | 2 | Pass type: 0 blend, 1 fade, 2 copy, 3 blend |
| fade_color | input | 24 | Constant colour used in fade mode |
| fade_level | input | 6 | Alpha used in fade mode |
| fg_valid | input | 1 | Foreground pixel valid |
| fg_ready | output | 1 | Foreground pixel accepted |
| fg_pix | input | 24 | Foreground pixel, three 8-bit components |
| fg_alpha | input | 6 | Alpha carried with the foreground pixel |
| bg_valid | input | 1 | Background pixel valid |
| bg_ready | output | 1 | Background pixel accepted |
| bg_pix | input | 24 | Background pixel, three 8-bit components |
| out_valid | output | 1 | Blended pixel valid |
| out_ready | input | 1 | Downstream accepts the blended pixel |
| out_pix | output | 24 | Blended pixel |
| out_last | output | 1 | Final pixel of a tile |

## Verification
The hardest case to reach from the ports is a configuration change that arrives mid-tile while the output is stalled. Here the latched settings must win over the live inputs for a pixel that has already been taken, and the output must hold. To create this case, the stimulus picks a new random mode, fade colour and fade level on every cycle. It also throttles both input streams and the output ready at independent random rates. Most tiles therefore see several rejected configuration changes, and many of those changes land in stall cycles. The alphas and fade levels are biased toward 0 and 63 so that the exact-passthrough endpoints come up often.

// File: rtl/mix_pkg.sv
package mix_pkg;

  typedef enum logic [1:0] {
    MIX_BLEND     = 2'd0,
    MIX_FADE      = 2'd1,
    MIX_COPY      = 2'd2,
    MIX_BLEND_ALT = 2'd3
  } mix_mode_e;

  // Weighted mix of two components with rounding; amax is full-scale alpha.
  function automatic int unsigned mix_div(int unsigned a, int unsigned top,
                                          int unsigned under, int unsigned amax);
    int unsigned num;
    num = a * top + (amax - a) * under + amax / 2;
    return num / amax;
  endfunction

endpackage

// File: rtl/mix_tile_ctl.sv
module mix_tile_ctl
  import mix_pkg::*;
#(
  parameter int PIX_W    = 24,
  parameter int ALPHA_W  = 6,
  parameter int TILE_PIX = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take,
  input  logic [1:0]         mode_cfg,
  input  logic [PIX_W-1:0]   fade_color,
  input  logic [ALPHA_W-1:0] fade_level,
  output mix_mode_e          cur_mode,
  output logic [PIX_W-1:0]   cur_color,
  output logic [ALPHA_W-1:0] cur_level,
  output logic               tile_last
);
  localparam int CNT_W = (TILE_PIX > 1) ? $clog2(TILE_PIX) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(TILE_PIX - 1);

  logic [CNT_W-1:0]   pos_q;
  mix_mode_e          mode_q;
  logic [PIX_W-1:0]   color_q;
  logic [ALPHA_W-1:0] level_q;
  logic               tile_first;

  assign tile_first = (pos_q == '0);
  assign tile_last  = (pos_q == LAST_IDX);

  // The first pixel of a tile uses the live settings; the rest use the latch.
  assign cur_mode  = tile_first ? mix_mode_e'(mode_cfg) : mode_q;
  assign cur_color = tile_first ? fade_color : color_q;
  assign cur_level = tile_first ? fade_level : level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q   <= '0;
      mode_q  <= MIX_BLEND;
      color_q <= '0;
      level_q <= '0;
    end else if (take) begin
      pos_q <= tile_last ? '0 : pos_q + 1'b1;
      if (tile_first) begin
        mode_q  <= mix_mode_e'(mode_cfg);
        color_q <= fade_color;
        level_q <= fade_level;
      end
    end
  end

endmodule

// File: rtl/mix_blend_lane.sv
module mix_blend_lane
  import mix_pkg::*;
#(
  parameter int CH_W    = 8,
  parameter int ALPHA_W = 6
) (
  input  logic [CH_W-1:0]    top_ch,
  input  logic [CH_W-1:0]    under_ch,
  input  logic [ALPHA_W-1:0] alpha,
  output logic [CH_W-1:0]    mix_ch
);
  localparam int unsigned AMAX = (1 << ALPHA_W) - 1;

  assign mix_ch = CH_W'(mix_div(32'(alpha), 32'(top_ch), 32'(under_ch), AMAX));

endmodule

// File: rtl/mix_out_stage.sv
module mix_out_stage #(
  parameter int PIX_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PIX_W-1:0] load_pix,
  input  logic             load_last,
  output logic             slot_free,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PIX_W-1:0] out_pix,
  output logic             out_last
);
  assign slot_free = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
      out_last  <= 1'b0;
    end else if (slot_free) begin
      out_valid <= load;
      if (load) begin
        out_pix  <= load_pix;
        out_last <= load_last;
      end
    end
  end

endmodule

// File: rtl/tile_alpha_mixer.sv
module tile_alpha_mixer
  import mix_pkg::*;
#(
  parameter int CH_W     = 8,
  parameter int N_CH     = 3,
  parameter int ALPHA_W  = 6,
  parameter int TILE_PIX = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             mode_cfg,
  input  logic [N_CH*CH_W-1:0]   fade_color,
  input  logic [ALPHA_W-1:0]     fade_level,
  input  logic                   fg_valid,
  output logic                   fg_ready,
  input  logic [N_CH*CH_W-1:0]   fg_pix,
  input  logic [ALPHA_W-1:0]     fg_alpha,
  input  logic                   bg_valid,
  output logic                   bg_ready,
  input  logic [N_CH*CH_W-1:0]   bg_pix,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [N_CH*CH_W-1:0]   out_pix,
  output logic                   out_last
);
  localparam int PIX_W = N_CH * CH_W;
  localparam logic [ALPHA_W-1:0] ALPHA_FULL = '1;

  logic               slot_free_w;
  logic               take_w;
  mix_mode_e          cur_mode_w;
  logic [PIX_W-1:0]   cur_color_w;
  logic [ALPHA_W-1:0] cur_level_w;
  logic               tile_last_w;
  logic [PIX_W-1:0]   top_sel_w;
  logic [ALPHA_W-1:0] alpha_sel_w;
  logic [PIX_W-1:0]   mixed_w;

  // Both streams move together; each ready depends on the other's valid.
  assign take_w   = fg_valid && bg_valid && slot_free_w;
  assign fg_ready = bg_valid && slot_free_w;
  assign bg_ready = fg_valid && slot_free_w;

  mix_tile_ctl #(
    .PIX_W   (PIX_W),
    .ALPHA_W (ALPHA_W),
    .TILE_PIX(TILE_PIX)
  ) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take_w),
    .mode_cfg  (mode_cfg),
    .fade_color(fade_color),
    .fade_level(fade_level),
    .cur_mode  (cur_mode_w),
    .cur_color (cur_color_w),
    .cur_level (cur_level_w),
    .tile_last (tile_last_w)
  );

  // Every pass type reduces to one blend with a chosen top layer and alpha.
  always_comb begin
    case (cur_mode_w)
      MIX_FADE: begin
        top_sel_w   = cur_color_w;
        alpha_sel_w = cur_level_w;
      end
      MIX_COPY: begin
        top_sel_w   = fg_pix;
        alpha_sel_w = ALPHA_FULL;
      end
      default: begin
        top_sel_w   = fg_pix;
        alpha_sel_w = fg_alpha;
      end
    endcase
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_lane
    mix_blend_lane #(
      .CH_W   (CH_W),
      .ALPHA_W(ALPHA_W)
    ) u_lane (
      .top_ch  (top_sel_w[c*CH_W +: CH_W]),
      .under_ch(bg_pix[c*CH_W +: CH_W]),
      .alpha   (alpha_sel_w),
      .mix_ch  (mixed_w[c*CH_W +: CH_W])
    );
  end

  mix_out_stage #(
    .PIX_W(PIX_W)
  ) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (take_w),
    .load_pix (mixed_w),
    .load_last(tile_last_w),
    .slot_free(slot_free_w),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_pix  (out_pix),
    .out_last (out_last)
  );

endmodule

// File: rtl/mix_chk.sv
module mix_chk #(
  parameter int PIX_W    = 24,
  parameter int ALPHA_W  = 6,
  parameter int TILE_PIX = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               take_w,
  input logic [1:0]         cur_mode_w,
  input logic               fg_valid,
  input logic               fg_ready,
  input logic [PIX_W-1:0]   fg_pix,
  input logic [ALPHA_W-1:0] fg_alpha,
  input logic               bg_valid,
  input logic               bg_ready,
  input logic [PIX_W-1:0]   bg_pix,
  input logic               out_valid,
  input logic               out_ready,
  input logic [PIX_W-1:0]   out_pix,
  input logic               out_last
);
  localparam int CNT_W = (TILE_PIX > 1) ? $clog2(TILE_PIX) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(TILE_PIX - 1);
  localparam logic [ALPHA_W-1:0] ALPHA_FULL = '1;

  logic [CNT_W-1:0] beat_q;
  logic             blend_like;

  assign blend_like = (cur_mode_w == 2'd0) || (cur_mode_w == 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) beat_q <= '0;
    else if (out_valid && out_ready) beat_q <= (beat_q == LAST_IDX) ? '0 : beat_q + 1'b1;
  end

  // R1
  always @(negedge clk) begin
    if (!rst_n) begin
      idle_in_reset_chk: assert (!out_valid);
    end
  end

  // R2
  paired_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fg_valid && fg_ready) == (bg_valid && bg_ready));

  // R2
  take_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fg_valid && fg_ready) |=> out_valid);

  // R4
  full_alpha_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_w && blend_like && fg_alpha == ALPHA_FULL) |=> out_pix == $past(fg_pix));

  // R4
  zero_alpha_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_w && blend_like && fg_alpha == '0) |=> out_pix == $past(bg_pix));

  // R6
  copy_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_w && cur_mode_w == 2'd2) |=> out_pix == $past(fg_pix));

  // R9
  tile_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |-> (out_last == (beat_q == LAST_IDX)));

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix) && $stable(out_last)));

  // R10
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !(fg_ready || bg_ready));

endmodule

bind tile_alpha_mixer mix_chk #(
  .PIX_W   (N_CH * CH_W),
  .ALPHA_W (ALPHA_W),
  .TILE_PIX(TILE_PIX)
) u_mix_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .take_w    (take_w),
  .cur_mode_w(cur_mode_w),
  .fg_valid  (fg_valid),
  .fg_ready  (fg_ready),
  .fg_pix    (fg_pix),
  .fg_alpha  (fg_alpha),
  .bg_valid  (bg_valid),
  .bg_ready  (bg_ready),
  .bg_pix    (bg_pix),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_pix   (out_pix),
  .out_last  (out_last)
);

// File: tb/test_tile_alpha_mixer.sv
`timescale 1ns/1ps
module test_tile_alpha_mixer;
  localparam int TILE = 16;
  localparam int AMAX = 63;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_cfg = '0;
  logic [23:0] fade_color = '0;
  logic [5:0]  fade_level = '0;
  logic        fg_valid = 1'b0, bg_valid = 1'b0, out_ready = 1'b0;
  logic        fg_ready, bg_ready, out_valid, out_last;
  logic [23:0] fg_pix = '0, bg_pix = '0, out_pix;
  logic [5:0]  fg_alpha = '0;

  always #10 clk = ~clk;

  tile_alpha_mixer i_tile_alpha_mixer (
    .clk(clk), .rst_n(rst_n), .mode_cfg(mode_cfg), .fade_color(fade_color),
    .fade_level(fade_level), .fg_valid(fg_valid), .fg_ready(fg_ready),
    .fg_pix(fg_pix), .fg_alpha(fg_alpha), .bg_valid(bg_valid),
    .bg_ready(bg_ready), .bg_pix(bg_pix), .out_valid(out_valid),
    .out_ready(out_ready), .out_pix(out_pix), .out_last(out_last)
  );

  int    n_tests = 0, n_fail = 0, n_out = 0;
  bit    done = 0;
  logic [24:0] exp_q[$];
  string       tag_q[$];
  int          m_pos = 0, m_mode = 0, m_lvl = 0;
  logic [23:0] m_col = '0;
  bit          held = 0;
  logic [24:0] held_val = '0;

  function automatic int ref_mix(int a, int f, int b);
    return (a * f + (AMAX - a) * b + AMAX / 2) / AMAX;
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [5:0] pick_alpha();
    int r = $urandom % 8;
    if (r == 0) return 6'd0;
    if (r == 1) return 6'd63;
    return 6'($urandom);
  endfunction

  // Settled port values here are those seen at the next rising edge.
  task automatic evaluate();
    bit fg_hs = fg_valid && fg_ready;
    bit bg_hs = bg_valid && bg_ready;
    if (fg_hs || bg_hs) check(fg_hs == bg_hs, "R2 paired accept", fg_hs, bg_hs);
    if (held) check(out_valid && {out_last, out_pix} == held_val, "R10 hold",
                    {out_valid, out_last, out_pix}, {1'b1, held_val});
    if (out_valid) begin
      if (exp_q.size() == 0) check(0, "R2 spurious output", out_pix, 0);
      else begin
        check(out_pix == exp_q[0][23:0], tag_q[0], out_pix, exp_q[0][23:0]);
        check(out_last == exp_q[0][24], "R9 last flag", out_last, exp_q[0][24]);
        if (out_ready) begin
          void'(exp_q.pop_front());
          void'(tag_q.pop_front());
          n_out++;
        end
      end
    end
    held = out_valid && !out_ready;
    held_val = {out_last, out_pix};
    if (fg_hs && bg_hs) begin
      logic [23:0] e;
      string t;
      int a;
      logic [23:0] top;
      if (m_pos == 0) begin
        m_mode = int'(mode_cfg);
        m_col = fade_color;
        m_lvl = int'(fade_level);
      end
      case (m_mode)
        1: begin top = m_col; a = m_lvl; t = "R5 fade R8"; end
        2: begin top = fg_pix; a = AMAX; t = "R6 copy R8"; end
        default: begin
          top = fg_pix; a = int'(fg_alpha);
          if (m_mode == 3) t = "R7 alt blend R8";
          else if (a == 0 || a == AMAX) t = "R4 endpoint R8";
          else t = "R3 blend R8";
        end
      endcase
      for (int c = 0; c < 3; c++)
        e[c*8 +: 8] = 8'(ref_mix(a, int'(top[c*8 +: 8]), int'(bg_pix[c*8 +: 8])));
      exp_q.push_back({(m_pos == TILE - 1), e});
      tag_q.push_back(t);
      m_pos = (m_pos == TILE - 1) ? 0 : m_pos + 1;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(!out_valid, "R1 reset idle", out_valid, 0);
    fg_valid = 1'b1; bg_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    check(!out_valid, "R1 reset held", out_valid, 0);
    fg_valid = 1'b0; bg_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid, "R1 after release", out_valid, 0);
    for (int cyc = 0; cyc < 6000; cyc++) begin
      @(negedge clk);
      fg_valid   = ($urandom % 4) != 0;
      bg_valid   = ($urandom % 4) != 0;
      out_ready  = (cyc < 1000) ? 1'b1 : (($urandom % 3) != 0);
      fg_pix     = 24'($urandom);
      bg_pix     = 24'($urandom);
      fg_alpha   = pick_alpha();
      mode_cfg   = 2'($urandom);
      fade_color = 24'($urandom);
      fade_level = pick_alpha();
      #1;
      evaluate();
    end
    fg_valid = 1'b0; bg_valid = 1'b0;
    for (int cyc = 0; cyc < 5; cyc++) begin
      @(negedge clk);
      out_ready = 1'b1;
      #1;
      evaluate();
    end
    // R2
    check(exp_q.size() == 0, "R2 outputs drained", exp_q.size(), 0);
    check(n_out > 500, "R2 output volume", n_out, 500);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(20.0 * 100000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule